// File: doc/BRIEF.md
# MSI-X Interrupt Cause and Mask Controller

This block collects interrupt causes from the rest of a device, holds them in a cause register, gates them with a per-cause enable mask and raises a one-cycle request on an MSI-X vector line whenever an enabled cause becomes pending. Software works it through a 32-bit register port. It can set and clear mask bits through separate set and clear registers, inject causes, and clear them either by writing ones or by reading. It can also choose which causes are cleared or masked automatically when their vector fires.

In multi-vector mode each cause is routed through its own byte of an allocation register, which holds a vector number and a valid flag. In single-vector mode every cause drives vector 0. An enable bit in the general-purpose register decides when auto-mask acts. With the bit set, auto-mask acts when the vector is asserted. With the bit clear, auto-mask acts when software reads or writes the cause register. Building the message on the bus and the vector table are left to the surrounding logic.

Top module: `msix_icm_top`

## Requirements
- R1: After reset the cause, mask, auto-clear, auto-mask, general-purpose and allocation registers all read as zero, and no vector request is raised.
- R2: A 1 on a `hw_cause_i` bit in a cycle, or a write of a 1 to that bit of the cause-set register (offset 0x1520), sets the cause bit at the next clock edge. The cause register (offset 0x1580) reads the cause bits in bits [NUM_CAUSE-1:0].
- R3: Writing the cause register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: Reading the cause register returns its value and then clears all cause bits at that clock edge.
- R5: A 1 written to a bit of mask-set (0x1524) enables that cause, and a 1 written to mask-clear (0x1528) disables it. Mask-set reads back the current mask. Mask-clear and cause-set read as zero.
- R6: A vector request is one cycle long. It is raised in the cycle after the clock edge at which some enabled pending cause routed to that vector first appears. While that condition stays true, no further request is raised.
- R7: When general-purpose bit 4 is set (offset 0x1514), cause i routes to the vector number held in bits [VIDX_W-1:0] of byte i of the allocation register (0x1700), and only while bit 7 of that byte is set. When bit 4 is clear, every cause routes to vector 0.
- R8: At the edge that ends a request on a vector, each cause routed to that vector whose auto-clear bit (0x152C) is set is cleared.
- R9: When general-purpose bit 30 is set, the edge that ends a request clears the mask bit of each routed cause whose auto-mask bit (0x1530) is set. Any later rise of that cause then raises no request until its mask bit is set again.
- R10: When general-purpose bit 30 is clear, a vector request leaves the mask unchanged. A read or write of the cause register clears every mask bit whose auto-mask bit is set.
- R11: When a cause bit is set and cleared in the same cycle, the set wins and the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; read side effects take place at the edge |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as rd_en_i, zero otherwise |
| hw_cause_i | input | NUM_CAUSE | Cause inputs from the device, sampled every clock |
| vec_req_o | output | NUM_VEC | One-cycle request per MSI-X vector |

## Verification
Register writes and cause inputs take effect at the next clock edge. A read returns its data in the same cycle as its strobe and applies its clear at the end of that cycle. A vector request appears in the cycle after the edge that makes its condition true. The auto-clear and auto-mask effects of that request land at the edge that ends it. The bench applies inputs on the falling edge and samples one nanosecond later. Its reference model advances on each rising edge, so the comparison made every cycle always sees state that has just settled. The scenario checks read registers and count request pulses only after a few idle cycles, so each of these latencies has passed before the check is made.

// File: rtl/msix_icm_pkg.sv
package msix_icm_pkg;

   // register byte offsets
   localparam logic [31:0] OFS_GPIE  = 32'h0000_1514;
   localparam logic [31:0] OFS_CSET  = 32'h0000_1520;
   localparam logic [31:0] OFS_MSET  = 32'h0000_1524;
   localparam logic [31:0] OFS_MCLR  = 32'h0000_1528;
   localparam logic [31:0] OFS_ACLR  = 32'h0000_152C;
   localparam logic [31:0] OFS_AMSK  = 32'h0000_1530;
   localparam logic [31:0] OFS_CAUSE = 32'h0000_1580;
   localparam logic [31:0] OFS_ALLOC = 32'h0000_1700;

   // general-purpose register fields
   localparam int GPIE_MULTI_BIT = 4;
   localparam int GPIE_AM_BIT    = 30;

   // allocation byte fields
   localparam int ALLOC_VALID_BIT = 7;
   localparam int ALLOC_LANE_W    = 8;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_GPIE,
      SEL_CSET,
      SEL_MSET,
      SEL_MCLR,
      SEL_ACLR,
      SEL_AMSK,
      SEL_CAUSE,
      SEL_ALLOC
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [31:0] a);
      reg_sel_e s;
      case (a)
         OFS_GPIE:  s = SEL_GPIE;
         OFS_CSET:  s = SEL_CSET;
         OFS_MSET:  s = SEL_MSET;
         OFS_MCLR:  s = SEL_MCLR;
         OFS_ACLR:  s = SEL_ACLR;
         OFS_AMSK:  s = SEL_AMSK;
         OFS_CAUSE: s = SEL_CAUSE;
         OFS_ALLOC: s = SEL_ALLOC;
         default:   s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/msix_icm_cfg.sv
module msix_icm_cfg
   import msix_icm_pkg::*;
#(
   parameter int NUM_CAUSE = 4,
   parameter int VIDX_W    = 2
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              wr_gpie_i,
   input  logic                              wr_aclr_i,
   input  logic                              wr_amsk_i,
   input  logic                              wr_alloc_i,
   input  logic [31:0]                       wdata_i,
   output logic                              multi_o,
   output logic                              am_assert_o,
   output logic [NUM_CAUSE-1:0]              aclr_o,
   output logic [NUM_CAUSE-1:0]              amsk_o,
   output logic [NUM_CAUSE-1:0]              valid_o,
   output logic [NUM_CAUSE-1:0][VIDX_W-1:0]  vidx_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         multi_o     <= 1'b0;
         am_assert_o <= 1'b0;
         aclr_o      <= '0;
         amsk_o      <= '0;
         valid_o     <= '0;
         vidx_o      <= '0;
      end else begin
         if (wr_gpie_i) begin
            multi_o     <= wdata_i[GPIE_MULTI_BIT];
            am_assert_o <= wdata_i[GPIE_AM_BIT];
         end
         if (wr_aclr_i) aclr_o <= wdata_i[NUM_CAUSE-1:0];
         if (wr_amsk_i) amsk_o <= wdata_i[NUM_CAUSE-1:0];
         if (wr_alloc_i) begin
            for (int i = 0; i < NUM_CAUSE; i++) begin
               valid_o[i] <= wdata_i[ALLOC_LANE_W*i + ALLOC_VALID_BIT];
               vidx_o[i]  <= wdata_i[ALLOC_LANE_W*i +: VIDX_W];
            end
         end
      end
   end

endmodule

// File: rtl/msix_icm_route.sv
module msix_icm_route #(
   parameter int NUM_CAUSE = 4,
   parameter int NUM_VEC   = 4,
   parameter int VIDX_W    = 2
) (
   input  logic                               multi_i,
   input  logic [NUM_CAUSE-1:0]               valid_i,
   input  logic [NUM_CAUSE-1:0][VIDX_W-1:0]   vidx_i,
   output logic [NUM_VEC-1:0][NUM_CAUSE-1:0]  map_o
);

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_cause
         if (v == 0) begin : g_base
            assign map_o[v][i] = multi_i ? (valid_i[i] && (32'(vidx_i[i]) == 32'(v)))
                                         : 1'b1;
         end else begin : g_other
            assign map_o[v][i] = multi_i && valid_i[i] && (32'(vidx_i[i]) == 32'(v));
         end
      end
   end

endmodule

// File: rtl/msix_icm_state.sv
module msix_icm_state #(
   parameter int NUM_CAUSE = 4,
   parameter int NUM_VEC   = 4
) (
   input  logic                               clk_i,
   input  logic                               rst_ni,
   input  logic [NUM_CAUSE-1:0]               hw_cause_i,
   input  logic [NUM_CAUSE-1:0]               wdata_i,
   input  logic                               cset_we_i,
   input  logic                               cause_we_i,
   input  logic                               cause_re_i,
   input  logic                               mset_we_i,
   input  logic                               mclr_we_i,
   input  logic [NUM_VEC-1:0][NUM_CAUSE-1:0]  map_i,
   input  logic [NUM_CAUSE-1:0]               aclr_i,
   input  logic [NUM_CAUSE-1:0]               amsk_i,
   input  logic                               am_assert_i,
   output logic [NUM_CAUSE-1:0]               cause_o,
   output logic [NUM_CAUSE-1:0]               mask_o,
   output logic [NUM_VEC-1:0]                 vec_req_o
);

   logic [NUM_CAUSE-1:0] cause_q, mask_q, cause_d, mask_d;
   logic [NUM_CAUSE-1:0] pend, hit, clr, mdrop;
   logic [NUM_VEC-1:0]   lvl, lvl_q, fire;

   always_comb begin
      pend = cause_q & mask_q;
      for (int v = 0; v < NUM_VEC; v++) lvl[v] = |(map_i[v] & pend);
      fire = lvl & ~lvl_q;
      hit  = '0;
      for (int v = 0; v < NUM_VEC; v++) if (fire[v]) hit = hit | map_i[v];

      clr = (hit & aclr_i)
          | (cause_we_i ? wdata_i : '0)
          | (cause_re_i ? '1 : '0);
      cause_d = (cause_q & ~clr) | hw_cause_i | (cset_we_i ? wdata_i : '0);

      mdrop = mclr_we_i ? wdata_i : '0;
      if (am_assert_i)                   mdrop = mdrop | (hit & amsk_i);
      else if (cause_we_i || cause_re_i) mdrop = mdrop | amsk_i;
      mask_d = (mask_q & ~mdrop) | (mset_we_i ? wdata_i : '0);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cause_q <= '0;
         mask_q  <= '0;
         lvl_q   <= '0;
      end else begin
         cause_q <= cause_d;
         mask_q  <= mask_d;
         lvl_q   <= lvl;
      end
   end

   assign cause_o   = cause_q;
   assign mask_o    = mask_q;
   assign vec_req_o = fire;

endmodule

// File: rtl/msix_icm_top.sv
module msix_icm_top
   import msix_icm_pkg::*;
#(
   parameter int NUM_CAUSE = 4,
   parameter int NUM_VEC   = 4,
   parameter int ADDR_W    = 16
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  wr_en_i,
   input  logic                  rd_en_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [31:0]           wdata_i,
   output logic [31:0]           rdata_o,
   input  logic [NUM_CAUSE-1:0]  hw_cause_i,
   output logic [NUM_VEC-1:0]    vec_req_o
);

   localparam int VIDX_W = $clog2(NUM_VEC);

   if (NUM_CAUSE < 1 || NUM_CAUSE > 4) begin : g_bad_cause
      $error("NUM_CAUSE must lie in 1..4, one allocation byte per cause");
   end
   if (NUM_VEC < 2 || NUM_VEC > 128) begin : g_bad_vec
      $error("NUM_VEC must lie in 2..128 so the vector field fits below the valid bit");
   end
   if (ADDR_W < 13 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 13..32 to reach every register offset");
   end

   reg_sel_e sel;
   logic     multi, am_assert;
   logic [NUM_CAUSE-1:0]              aclr, amsk, valid, cause_w, mask_w;
   logic [NUM_CAUSE-1:0][VIDX_W-1:0]  vidx;
   logic [NUM_VEC-1:0][NUM_CAUSE-1:0] map;
   logic [31:0] alloc_rd, rd_mux;
   logic        unused_wdata;

   assign sel          = decode_addr(32'(addr_i));
   assign unused_wdata = ^wdata_i;

   msix_icm_cfg #(.NUM_CAUSE(NUM_CAUSE), .VIDX_W(VIDX_W)) cfg_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_gpie_i   (wr_en_i && sel == SEL_GPIE),
      .wr_aclr_i   (wr_en_i && sel == SEL_ACLR),
      .wr_amsk_i   (wr_en_i && sel == SEL_AMSK),
      .wr_alloc_i  (wr_en_i && sel == SEL_ALLOC),
      .wdata_i     (wdata_i),
      .multi_o     (multi),
      .am_assert_o (am_assert),
      .aclr_o      (aclr),
      .amsk_o      (amsk),
      .valid_o     (valid),
      .vidx_o      (vidx)
   );

   msix_icm_route #(.NUM_CAUSE(NUM_CAUSE), .NUM_VEC(NUM_VEC), .VIDX_W(VIDX_W)) route_i (
      .multi_i (multi),
      .valid_i (valid),
      .vidx_i  (vidx),
      .map_o   (map)
   );

   msix_icm_state #(.NUM_CAUSE(NUM_CAUSE), .NUM_VEC(NUM_VEC)) state_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hw_cause_i  (hw_cause_i),
      .wdata_i     (wdata_i[NUM_CAUSE-1:0]),
      .cset_we_i   (wr_en_i && sel == SEL_CSET),
      .cause_we_i  (wr_en_i && sel == SEL_CAUSE),
      .cause_re_i  (rd_en_i && sel == SEL_CAUSE),
      .mset_we_i   (wr_en_i && sel == SEL_MSET),
      .mclr_we_i   (wr_en_i && sel == SEL_MCLR),
      .map_i       (map),
      .aclr_i      (aclr),
      .amsk_i      (amsk),
      .am_assert_i (am_assert),
      .cause_o     (cause_w),
      .mask_o      (mask_w),
      .vec_req_o   (vec_req_o)
   );

   always_comb begin
      alloc_rd = '0;
      for (int i = 0; i < NUM_CAUSE; i++) begin
         alloc_rd[ALLOC_LANE_W*i +: VIDX_W]           = vidx[i];
         alloc_rd[ALLOC_LANE_W*i + ALLOC_VALID_BIT]   = valid[i];
      end
   end

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_GPIE: begin
            rd_mux[GPIE_MULTI_BIT] = multi;
            rd_mux[GPIE_AM_BIT]    = am_assert;
         end
         SEL_MSET:  rd_mux[NUM_CAUSE-1:0] = mask_w;
         SEL_ACLR:  rd_mux[NUM_CAUSE-1:0] = aclr;
         SEL_AMSK:  rd_mux[NUM_CAUSE-1:0] = amsk;
         SEL_CAUSE: rd_mux[NUM_CAUSE-1:0] = cause_w;
         SEL_ALLOC: rd_mux = alloc_rd;
         default:   rd_mux = '0;
      endcase
   end

   assign rdata_o = rd_en_i ? rd_mux : 32'h0;

endmodule

// File: rtl/msix_icm_chk.sv
module msix_icm_chk
   import msix_icm_pkg::*;
#(
   parameter int NUM_CAUSE = 4,
   parameter int NUM_VEC   = 4,
   parameter int ADDR_W    = 16
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  wr_en_i,
   input logic                  rd_en_i,
   input logic [ADDR_W-1:0]     addr_i,
   input logic [NUM_CAUSE-1:0]  wdata_i,
   input logic [NUM_CAUSE-1:0]  hw_cause_i,
   input logic [NUM_VEC-1:0]    vec_req_o,
   input logic [NUM_CAUSE-1:0]  cause_q,
   input logic [NUM_CAUSE-1:0]  mask_q
);

   // R1
   r1_reset_idle_chk: assert property (@(posedge clk_i)
      !rst_ni |=> (cause_q == '0 && mask_q == '0 && vec_req_o == '0));

   // R2
   r2_cause_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((cause_q & $past(hw_cause_i)) == $past(hw_cause_i)));

   // R3
   r3_write_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(OFS_CAUSE))
      |=> ((cause_q & $past(wdata_i) & ~$past(hw_cause_i)) == '0));

   // R5
   r5_mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(OFS_MSET))
      |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

   // R9
   r9_mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i && !rd_en_i && vec_req_o == '0)
      |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      // R6
      r6_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         vec_req_o[v] |=> !vec_req_o[v]);
   end

endmodule

bind msix_icm_top msix_icm_chk #(
   .NUM_CAUSE (NUM_CAUSE),
   .NUM_VEC   (NUM_VEC),
   .ADDR_W    (ADDR_W)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .wr_en_i    (wr_en_i),
   .rd_en_i    (rd_en_i),
   .addr_i     (addr_i),
   .wdata_i    (wdata_i[NUM_CAUSE-1:0]),
   .hw_cause_i (hw_cause_i),
   .vec_req_o  (vec_req_o),
   .cause_q    (cause_w),
   .mask_q     (mask_w)
);

// File: tb/msix_icm_top_tb_top.sv
`timescale 1ns/100ps
module msix_icm_top_tb_top;

   localparam int NC = 4;
   localparam int NV = 4;

   localparam logic [15:0] A_GPIE  = 16'h1514;
   localparam logic [15:0] A_CSET  = 16'h1520;
   localparam logic [15:0] A_MSET  = 16'h1524;
   localparam logic [15:0] A_MCLR  = 16'h1528;
   localparam logic [15:0] A_ACLR  = 16'h152C;
   localparam logic [15:0] A_AMSK  = 16'h1530;
   localparam logic [15:0] A_CAUSE = 16'h1580;
   localparam logic [15:0] A_ALLOC = 16'h1700;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [15:0]   addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NC-1:0] hw = '0;
   logic [NV-1:0] vreq;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R1";
   int    pulse_cnt [NV];

   always #2.5 clk = ~clk;

   msix_icm_top dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .wr_en_i    (wr_en),
      .rd_en_i    (rd_en),
      .addr_i     (addr),
      .wdata_i    (wdata),
      .rdata_o    (rdata),
      .hw_cause_i (hw),
      .vec_req_o  (vreq)
   );

   // ---------------- behavioural reference model ----------------
   bit [NC-1:0] m_cause, m_mask, m_aclr, m_amsk, m_valid;
   int          m_vec [NC];
   bit          m_multi, m_am;
   bit [NV-1:0] m_lvlq;

   function automatic int route(int i);
      if (!m_multi) return 0;
      if (!m_valid[i]) return -1;
      return m_vec[i];
   endfunction

   function automatic bit level(int v);
      for (int i = 0; i < NC; i++)
         if (route(i) == v && m_cause[i] && m_mask[i]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [31:0] exp_rd(logic [15:0] a);
      logic [31:0] d;
      d = '0;
      case (a)
         A_GPIE:  begin d[4] = m_multi; d[30] = m_am; end
         A_MSET:  d[NC-1:0] = m_mask;
         A_ACLR:  d[NC-1:0] = m_aclr;
         A_AMSK:  d[NC-1:0] = m_amsk;
         A_CAUSE: d[NC-1:0] = m_cause;
         A_ALLOC: for (int i = 0; i < NC; i++) begin
                     d[8*i +: 7] = 7'(m_vec[i]);
                     d[8*i + 7]  = m_valid[i];
                  end
         default: d = '0;
      endcase
      return d;
   endfunction

   always @(posedge clk) begin : model
      bit [NV-1:0] lv, fire;
      bit [NC-1:0] hit, nc, nm;
      if (!rst_n) begin
         m_cause = '0; m_mask = '0; m_aclr = '0; m_amsk = '0; m_valid = '0;
         m_multi = 0; m_am = 0; m_lvlq = '0;
         for (int i = 0; i < NC; i++) m_vec[i] = 0;
      end else begin
         for (int v = 0; v < NV; v++) lv[v] = level(v);
         fire = lv & ~m_lvlq;
         for (int i = 0; i < NC; i++) begin
            int r;
            bit clr, drop;
            r = route(i);
            hit[i] = (r >= 0) && fire[r];
            clr = (hit[i] && m_aclr[i])
               || (wr_en && addr == A_CAUSE && wdata[i])
               || (rd_en && addr == A_CAUSE);
            nc[i] = (m_cause[i] && !clr) || hw[i] || (wr_en && addr == A_CSET && wdata[i]);
            drop = (wr_en && addr == A_MCLR && wdata[i])
                || (m_am && hit[i] && m_amsk[i])
                || (!m_am && m_amsk[i] && (wr_en || rd_en) && addr == A_CAUSE);
            nm[i] = (m_mask[i] && !drop) || (wr_en && addr == A_MSET && wdata[i]);
         end
         if (wr_en && addr == A_GPIE) begin m_multi = wdata[4]; m_am = wdata[30]; end
         if (wr_en && addr == A_ACLR) m_aclr = wdata[NC-1:0];
         if (wr_en && addr == A_AMSK) m_amsk = wdata[NC-1:0];
         if (wr_en && addr == A_ALLOC)
            for (int i = 0; i < NC; i++) begin
               m_valid[i] = wdata[8*i + 7];
               m_vec[i]   = int'(wdata[8*i +: 2]);
            end
         m_cause = nc;
         m_mask  = nm;
         m_lvlq  = lv;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         logic [NV-1:0] ev;
         for (int v = 0; v < NV; v++) ev[v] = level(v) && !m_lvlq[v];
         chk(vreq === ev, {cur_req, " vector request"}, 32'(vreq), 32'(ev));
         if (rd_en) chk(rdata === exp_rd(addr), {cur_req, " read data"}, rdata, exp_rd(addr));
         for (int v = 0; v < NV; v++) if (vreq[v] === 1'b1) pulse_cnt[v]++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(logic [15:0] a, logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(logic [15:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic hw_hold(logic [NC-1:0] m, int n);
      @(negedge clk); hw = m;
      repeat (n) @(negedge clk);
      hw = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   int snap [NV];
   task automatic take_snap();
      for (int v = 0; v < NV; v++) snap[v] = pulse_cnt[v];
   endtask

   task automatic chk_pulses(string req, int v, int exp);
      chk(pulse_cnt[v] - snap[v] == exp, req, 32'(pulse_cnt[v] - snap[v]), 32'(exp));
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      for (int v = 0; v < NV; v++) pulse_cnt[v] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R1: reset state
      cur_req = "R1";
      rd(A_CAUSE, d); chk(d == 32'h0, "R1 cause after reset", d, 32'h0);
      rd(A_MSET, d);  chk(d == 32'h0, "R1 mask after reset", d, 32'h0);
      rd(A_GPIE, d);  chk(d == 32'h0, "R1 gpie after reset", d, 32'h0);
      rd(A_ALLOC, d); chk(d == 32'h0, "R1 alloc after reset", d, 32'h0);

      // R2 latch from input and cause-set; R4 read clears
      cur_req = "R2";
      hw_hold(4'b0010, 1);
      wr(A_CSET, 32'h4);
      rd(A_CAUSE, d); chk(d == 32'h6, "R2 latched causes", d, 32'h6);
      cur_req = "R4";
      rd(A_CAUSE, d); chk(d == 32'h0, "R4 read-to-clear", d, 32'h0);

      // R3 write-one-to-clear, zeros ignored
      cur_req = "R3";
      wr(A_CSET, 32'hF);
      wr(A_CAUSE, 32'h3);
      wr(A_CAUSE, 32'h0);
      rd(A_CAUSE, d); chk(d == 32'hC, "R3 write-to-clear", d, 32'hC);

      // R5 mask set/clear and readback
      cur_req = "R5";
      wr(A_MSET, 32'h5);
      rd(A_MSET, d); chk(d == 32'h5, "R5 mask set", d, 32'h5);
      wr(A_MCLR, 32'h1);
      rd(A_MSET, d); chk(d == 32'h4, "R5 mask clear", d, 32'h4);
      rd(A_MCLR, d); chk(d == 32'h0, "R5 mask-clear reads zero", d, 32'h0);
      rd(A_CSET, d); chk(d == 32'h0, "R5 cause-set reads zero", d, 32'h0);
      wr(A_MCLR, 32'hF);

      // R6 one pulse per rising condition, single-vector routing (R7)
      cur_req = "R6";
      wr(A_MSET, 32'h1);
      take_snap();
      hw_hold(4'b0001, 6);
      idle(4);
      chk_pulses("R6 one pulse for held level", 0, 1);
      wr(A_CAUSE, 32'hF);
      idle(2);
      hw_hold(4'b0001, 1);
      idle(3);
      chk_pulses("R6 new edge gives new pulse", 0, 2);
      wr(A_CAUSE, 32'hF);

      // R7 multi-vector routing through allocation bytes
      cur_req = "R7";
      wr(A_MCLR, 32'hF);
      wr(A_GPIE, 32'h10);
      wr(A_ALLOC, 32'h0081_0382);
      rd(A_ALLOC, d); chk(d == 32'h0081_0382, "R7 alloc readback", d, 32'h0081_0382);
      wr(A_MSET, 32'h7);
      take_snap();
      hw_hold(4'b0010, 1);
      idle(3);
      for (int v = 0; v < NV; v++) chk_pulses("R7 invalid entry silent", v, 0);
      hw_hold(4'b0001, 1);
      idle(3);
      chk_pulses("R7 cause0 to vector2", 2, 1);
      chk_pulses("R7 vector0 idle in multi mode", 0, 0);
      hw_hold(4'b0100, 1);
      idle(3);
      chk_pulses("R7 cause2 to vector1", 1, 1);
      wr(A_CAUSE, 32'hF);

      // R8 auto-clear on assertion
      cur_req = "R8";
      wr(A_ACLR, 32'h1);
      take_snap();
      hw_hold(4'b0001, 1);
      idle(3);
      chk_pulses("R8 pulse", 2, 1);
      rd(A_CAUSE, d); chk(d == 32'h0, "R8 cause auto-cleared", d, 32'h0);
      hw_hold(4'b0001, 1);
      idle(3);
      chk_pulses("R8 re-raise pulses again", 2, 2);

      // R9 auto-mask on assertion
      cur_req = "R9";
      wr(A_GPIE, 32'h4000_0010);
      wr(A_AMSK, 32'h1);
      take_snap();
      hw_hold(4'b0001, 1);
      idle(3);
      chk_pulses("R9 first pulse", 2, 1);
      rd(A_MSET, d); chk(d == 32'h6, "R9 mask auto-cleared", d, 32'h6);
      hw_hold(4'b0001, 1);
      idle(3);
      chk_pulses("R9 masked re-raise silent", 2, 1);
      rd(A_CAUSE, d); chk(d == 32'h1, "R9 cause held while masked", d, 32'h1);

      // R10 auto-mask on cause access only
      cur_req = "R10";
      wr(A_GPIE, 32'h10);
      wr(A_MSET, 32'h1);
      take_snap();
      hw_hold(4'b0001, 1);
      idle(3);
      chk_pulses("R10 pulse", 2, 1);
      rd(A_MSET, d); chk(d == 32'h7, "R10 assertion leaves mask", d, 32'h7);
      wr(A_CAUSE, 32'h0);
      rd(A_MSET, d); chk(d == 32'h6, "R10 cause access masks", d, 32'h6);

      // R11 set wins over same-cycle clear
      cur_req = "R11";
      wr(A_ACLR, 32'h0);
      wr(A_MCLR, 32'hF);
      wr(A_CAUSE, 32'hF);
      @(negedge clk); hw = 4'b1000; wr_en = 1'b1; addr = A_CAUSE; wdata = 32'h8;
      @(negedge clk); hw = '0; wr_en = 1'b0; wdata = '0;
      rd(A_CAUSE, d); chk(d == 32'h8, "R11 set beats clear", d, 32'h8);

      idle(3);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule